// File: doc/BRIEF.md
# Compare Register Shadow Transfer Unit

This block keeps two copies of the timing registers of a three-phase PWM timer. There are four compare values: one for the timer base and one for each of the phases U, V and W. There is also a repetition value. Software writes new values into the shadow copies over a simple write stream. The block then moves them into the active copies that the timer uses. The moment of that move is chosen by a mode bit in a control word.

In hardware mode, a strobe from the repetition counter loads all five active registers together. In software mode, that strobe is ignored. Instead, writing the control word with the command bit set starts a transfer on the next clock edge, and the command bit then clears itself. A five-bit lane mask in the same control word chooses which active registers take part. A lane whose mask bit is clear keeps its old active value. Every transfer, whatever its source, produces a one-cycle done pulse.

The write stream uses valid/ready. The block never applies back-pressure: `wr_ready` is always high, and a beat is taken on every clock edge where `wr_valid` is high. The control word can be read at any time on `ctrl_status`.

Top module: `cmp_xfer_unit`

## Requirements
- R1: After reset, every shadow and active register is 0, `ctrl_status` is 0 (hardware mode, command clear, all lane mask bits clear) and `xfer_done` is 0.
- R2: `wr_ready` is always 1. A beat written to address 0 (timer-base compare), 1 (phase U), 2 (phase V), 3 (phase W) or 4 (repetition, low REP_W bits) updates only that shadow copy, and the active outputs do not change. Addresses 6 and 7 are ignored.
- R3: In hardware mode (`ctrl_status[0]`=0), a clock edge where `rep_expire` is high copies all five shadow values into their active registers, whatever the lane mask holds. The new values are visible after that edge.
- R4: Address 5 is the control word: bit 0 is the mode (1 = software), bit 1 is the command, and bits 6:2 are the lane mask (bit 2 timer base, 3 U, 4 V, 5 W, 6 repetition). `ctrl_status` reads back the same layout. A command accepted on one edge reads back as 1 for exactly one cycle and is cleared on the next edge.
- R5: In software mode, the edge after a command is accepted copies the shadow into the active register for exactly those lanes whose mask bit is 1. Lanes whose mask bit is 0 keep their active value.
- R6: In software mode, `rep_expire` has no effect on the active registers or on `xfer_done`.
- R7: A control write with command 1 and mode 0 drops the command. `ctrl_status[1]` reads 0 after it, and no transfer follows.
- R8: A control write with command 0 starts no transfer.
- R9: If a shadow write and a transfer fall on the same edge, the active register takes the shadow value held before that write.
- R10: `xfer_done` is high for exactly the one cycle after each edge on which a transfer fires, including a software transfer whose mask is all zero. At all other times it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | output | 1 | Write beat ready, always 1 |
| wr_addr | input | ADDR_W | Write address (0..5 used) |
| wr_data | input | CMP_W | Write data |
| rep_expire | input | 1 | Repetition counter expiry strobe |
| act_c0 | output | CMP_W | Active timer-base compare |
| act_cu | output | CMP_W | Active phase U compare |
| act_cv | output | CMP_W | Active phase V compare |
| act_cw | output | CMP_W | Active phase W compare |
| act_rep | output | REP_W | Active repetition value |
| xfer_done | output | 1 | One-cycle pulse after each transfer |
| ctrl_status | output | 7 | Control word readback |

## Verification
Some rules are checked by the bound properties on every cycle. These are: the command clearing itself, and being refused when the mode bit is 0; full loading on a hardware strobe, taken from the shadow values of the cycle before; masked lanes holding their value; the strobe being ignored in software mode; and the done pulse following exactly from a transfer event. Other rules depend on the sequence of writes, and only the bench scenarios show them. These are the address decode of shadow writes, the readback layout, the old value winning when a write meets a transfer, and the equality of whole register contents over long random runs, which is checked against a model kept in the bench.

// File: rtl/cmpx_pkg.sv
package cmpx_pkg;
  localparam int NUM_CMP  = 4;
  localparam int NUM_LANE = NUM_CMP + 1;
  localparam int REP_LANE = NUM_CMP;
  localparam int CTRL_SEL = NUM_LANE;
  localparam int CB_SW    = 0;
  localparam int CB_CMD   = 1;
  localparam int CB_EN    = 2;
  localparam int CTRL_W   = CB_EN + NUM_LANE;

  typedef struct packed {
    logic [NUM_LANE-1:0] en;
    logic                cmd;
    logic                sw;
  } ctrl_t;
endpackage

// File: rtl/cmpx_ctrl.sv
module cmpx_ctrl
  import cmpx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic                rep_expire,
  output ctrl_t               ctrl_q,
  output logic [NUM_LANE-1:0] load,
  output logic                done_q
);
  logic  ctrl_hit;
  logic  hw_fire;
  logic  sw_fire;
  ctrl_t ctrl_d;

  assign ctrl_hit = wr_fire && (wr_addr == ADDR_W'(CTRL_SEL));
  assign hw_fire  = !ctrl_q.sw && rep_expire;
  assign sw_fire  = ctrl_q.cmd;

  always_comb begin
    for (int i = 0; i < NUM_LANE; i++) begin
      load[i] = hw_fire || (sw_fire && ctrl_q.en[i]);
    end
  end

  always_comb begin
    ctrl_d     = ctrl_q;
    ctrl_d.cmd = 1'b0;
    if (ctrl_hit) begin
      ctrl_d.sw  = wr_data[CB_SW];
      ctrl_d.en  = wr_data[CB_EN +: NUM_LANE];
      ctrl_d.cmd = wr_data[CB_CMD] && wr_data[CB_SW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      done_q <= hw_fire || sw_fire;
    end
  end
endmodule

// File: rtl/cmpx_lane.sv
module cmpx_lane #(
  parameter int W      = 16,
  parameter int ADDR_W = 3,
  parameter int SEL    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic              load,
  output logic [W-1:0]      shadow_q,
  output logic [W-1:0]      active_q
);
  logic hit;
  assign hit = wr_fire && (wr_addr == ADDR_W'(SEL));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (load) active_q <= shadow_q;
      if (hit)  shadow_q <= wr_data;
    end
  end
endmodule

// File: rtl/cmp_xfer_unit.sv
module cmp_xfer_unit
  import cmpx_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int REP_W  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CMP_W-1:0]  wr_data,
  input  logic              rep_expire,
  output logic [CMP_W-1:0]  act_c0,
  output logic [CMP_W-1:0]  act_cu,
  output logic [CMP_W-1:0]  act_cv,
  output logic [CMP_W-1:0]  act_cw,
  output logic [REP_W-1:0]  act_rep,
  output logic              xfer_done,
  output logic [CTRL_W-1:0] ctrl_status
);
  logic                             wr_fire;
  ctrl_t                            ctrl_q;
  logic [NUM_LANE-1:0]              load;
  logic [NUM_CMP-1:0][CMP_W-1:0]    cmp_shd;
  logic [NUM_CMP-1:0][CMP_W-1:0]    cmp_act;
  logic [REP_W-1:0]                 rep_shd;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  cmpx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_fire    (wr_fire),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data[CTRL_W-1:0]),
    .rep_expire (rep_expire),
    .ctrl_q     (ctrl_q),
    .load       (load),
    .done_q     (xfer_done)
  );

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    cmpx_lane #(.W(CMP_W), .ADDR_W(ADDR_W), .SEL(i)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_fire  (wr_fire),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .load     (load[i]),
      .shadow_q (cmp_shd[i]),
      .active_q (cmp_act[i])
    );
  end

  cmpx_lane #(.W(REP_W), .ADDR_W(ADDR_W), .SEL(REP_LANE)) u_rep (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data[REP_W-1:0]),
    .load     (load[REP_LANE]),
    .shadow_q (rep_shd),
    .active_q (act_rep)
  );

  assign act_c0      = cmp_act[0];
  assign act_cu      = cmp_act[1];
  assign act_cv      = cmp_act[2];
  assign act_cw      = cmp_act[3];
  assign ctrl_status = ctrl_q;
endmodule

// File: rtl/cmpx_checker.sv
module cmpx_checker
  import cmpx_pkg::*;
#(
  parameter int CMP_W  = 16,
  parameter int REP_W  = 8,
  parameter int ADDR_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wr_valid,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [1:0]                    wr_lo,
  input logic                          rep_expire,
  input logic [CTRL_W-1:0]             ctrl_status,
  input logic                          xfer_done,
  input logic [NUM_CMP-1:0][CMP_W-1:0] cmp_shd,
  input logic [NUM_CMP-1:0][CMP_W-1:0] cmp_act,
  input logic [REP_W-1:0]              rep_shd,
  input logic [REP_W-1:0]              act_rep
);
  logic                sw;
  logic                cmd;
  logic [NUM_LANE-1:0] en;
  logic                ctrl_wr;
  logic                hw_evt;
  logic                any_evt;

  assign sw      = ctrl_status[CB_SW];
  assign cmd     = ctrl_status[CB_CMD];
  assign en      = ctrl_status[CB_EN +: NUM_LANE];
  assign ctrl_wr = wr_valid && (wr_addr == ADDR_W'(CTRL_SEL));
  assign hw_evt  = !sw && rep_expire;
  assign any_evt = hw_evt || cmd;

  // R4: a pending command lasts one cycle unless rewritten
  p_cmd_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !(ctrl_wr && wr_lo == 2'b11)) |=> !cmd);

  // R7: a control write with mode 0 never leaves a command pending
  p_cmd_needs_sw_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !wr_lo[0]) |=> !cmd);

  // R6: strobe ignored in software mode
  p_sw_ignores_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw && !cmd && rep_expire) |=> ($stable(act_rep) && $stable(cmp_act) && !xfer_done));

  // R10: done pulse only follows a transfer event
  p_done_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    any_evt |=> xfer_done);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !any_evt |=> !xfer_done);

  // R3 and R5 on the repetition lane
  p_hw_load_rep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> (act_rep == $past(rep_shd)));
  p_sw_load_rep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && en[REP_LANE]) |=> (act_rep == $past(rep_shd)));
  p_mask_hold_rep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd && !en[REP_LANE]) |=> $stable(act_rep));

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_lane
    // R3: every compare lane loads on a hardware strobe
    p_hw_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_evt |=> (cmp_act[i] == $past(cmp_shd[i])));
    // R5: enabled lanes load, masked lanes hold
    p_sw_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd && en[i]) |=> (cmp_act[i] == $past(cmp_shd[i])));
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd && !en[i]) |=> $stable(cmp_act[i]));
  end
endmodule

bind cmp_xfer_unit cmpx_checker #(
  .CMP_W (CMP_W),
  .REP_W (REP_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_addr    (wr_addr),
  .wr_lo      (wr_data[1:0]),
  .rep_expire (rep_expire),
  .ctrl_status(ctrl_status),
  .xfer_done  (xfer_done),
  .cmp_shd    (cmp_shd),
  .cmp_act    (cmp_act),
  .rep_shd    (rep_shd),
  .act_rep    (act_rep)
);

// File: tb/sim_cmp_xfer_unit.sv
module sim_cmp_xfer_unit;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic        wr_ready;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        rep_expire;
  logic [15:0] act_c0, act_cu, act_cv, act_cw;
  logic [7:0]  act_rep;
  logic        xfer_done;
  logic [6:0]  ctrl_status;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [15:0] m_shd [5];
  logic [15:0] m_act [5];
  logic        m_sw, m_cmd, m_done;
  logic [4:0]  m_en;

  always #(CLK_NS/2) clk = ~clk;

  cmp_xfer_unit u0 (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rep_expire(rep_expire),
    .act_c0(act_c0), .act_cu(act_cu), .act_cv(act_cv), .act_cw(act_cw),
    .act_rep(act_rep), .xfer_done(xfer_done), .ctrl_status(ctrl_status)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] lane_fit(int i, logic [15:0] v);
    return (i == 4) ? {8'h00, v[7:0]} : v;
  endfunction

  function automatic logic [6:0] exp_status();
    return {m_en, m_cmd, m_sw};
  endfunction

  function automatic logic [15:0] got_act(int i);
    case (i)
      0: return act_c0;
      1: return act_cu;
      2: return act_cv;
      3: return act_cw;
      default: return {8'h00, act_rep};
    endcase
  endfunction

  task automatic compare_all();
    chk("R2 wr_ready", wr_ready, 1);
    for (int i = 0; i < 5; i++) chk($sformatf("R3 R5 R9 active lane %0d", i), got_act(i), m_act[i]);
    chk("R10 xfer_done", xfer_done, m_done);
    chk("R4 ctrl_status", ctrl_status, exp_status());
  endtask

  task automatic step(bit v, logic [2:0] a, logic [15:0] d, bit rep);
    bit fire_hw, fire_sw;
    wr_valid = v; wr_addr = a; wr_data = d; rep_expire = rep;
    @(posedge clk);
    fire_hw = !m_sw && rep;
    fire_sw = m_cmd;
    for (int i = 0; i < 5; i++)
      if (fire_hw || (fire_sw && m_en[i])) m_act[i] = m_shd[i];
    m_done = fire_hw || fire_sw;
    m_cmd  = 1'b0;
    if (v) begin
      if (a < 3'd5) m_shd[int'(a)] = lane_fit(int'(a), d);
      else if (a == 3'd5) begin
        m_sw = d[0]; m_en = d[6:2]; m_cmd = d[1] & d[0];
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 3'd0, 16'h0, 0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_valid = 0; wr_addr = 0; wr_data = 0; rep_expire = 0;
    for (int i = 0; i < 5; i++) begin m_shd[i] = 0; m_act[i] = 0; end
    m_sw = 0; m_cmd = 0; m_done = 0; m_en = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset act_c0", act_c0, 0);
    chk("R1 reset act_rep", act_rep, 0);
    chk("R1 reset ctrl_status", ctrl_status, 0);
    chk("R1 reset xfer_done", xfer_done, 0);
    rst_n = 1'b1;

    // R2: shadow writes leave actives alone
    step(1, 3'd0, 16'h1111, 0);
    step(1, 3'd1, 16'h2222, 0);
    step(1, 3'd2, 16'h3333, 0);
    step(1, 3'd3, 16'h4444, 0);
    step(1, 3'd4, 16'hAB55, 0);
    step(1, 3'd6, 16'hFFFF, 0);
    chk("R2 active untouched", act_c0, 16'h0000);
    // R3: hardware strobe loads all lanes
    step(0, 3'd0, 16'h0, 1);
    chk("R3 lane W", act_cw, 16'h4444);
    chk("R3 lane rep", act_rep, 8'h55);
    chk("R10 pulse high", xfer_done, 1);
    idle();
    chk("R10 pulse one cycle", xfer_done, 0);

    // R4/R5: software mode, mask on base and V lanes
    step(1, 3'd5, 16'h0015, 0);
    chk("R4 mode readback", ctrl_status, 7'h15);
    step(1, 3'd0, 16'hA0A0, 0);
    step(1, 3'd2, 16'hC0C0, 0);
    step(1, 3'd1, 16'hB0B0, 0);
    step(1, 3'd5, 16'h0017, 0);
    chk("R4 cmd visible", ctrl_status[1], 1);
    idle();
    chk("R4 cmd self clears", ctrl_status[1], 0);
    chk("R5 base loads", act_c0, 16'hA0A0);
    chk("R5 V loads", act_cv, 16'hC0C0);
    chk("R5 U held", act_cu, 16'h2222);
    chk("R5 rep held", act_rep, 8'h55);

    // R6: strobe ignored in software mode
    step(1, 3'd0, 16'h5A5A, 1);
    chk("R6 no load", act_c0, 16'hA0A0);
    chk("R6 no pulse", xfer_done, 0);

    // R8: command 0 does nothing
    step(1, 3'd5, 16'h0015, 0);
    idle();
    chk("R8 no pulse", xfer_done, 0);
    chk("R8 no load", act_c0, 16'hA0A0);

    // R9: write and transfer on the same edge
    step(1, 3'd5, 16'h0017, 0);
    step(1, 3'd0, 16'h7777, 0);
    chk("R9 old shadow wins", act_c0, 16'h5A5A);
    step(1, 3'd5, 16'h0017, 0);
    idle();
    chk("R9 new value next time", act_c0, 16'h7777);

    // R7: command refused in hardware mode
    step(1, 3'd5, 16'h0016, 0);
    chk("R7 cmd reads 0", ctrl_status, 7'h14);
    step(1, 3'd1, 16'h1357, 0);
    chk("R7 no pulse", xfer_done, 0);
    chk("R7 no load", act_c0, 16'h7777);
    // R3: mask ignored on hardware strobe
    step(0, 3'd0, 16'h0, 1);
    chk("R3 mask ignored", act_cu, 16'h1357);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      bit          v;
      logic [2:0]  a;
      logic [15:0] d;
      bit          r;
      v = ($urandom % 2) == 0;
      a = 3'($urandom % 8);
      d = 16'($urandom);
      r = ($urandom % 5) == 0;
      step(v, a, d, r);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule